// File: doc/BRIEF.md
# GPIO Bank with Edge-Detect Interrupts

This block is a register-mapped general-purpose pin controller for up to 64 pins. The pins are held as two 32-bit banks: pin n sits in bank n/32 at bit n%32. Each pin has three controls. The output-enable bit turns the pin driver on. The output-value bit sets the level the driver puts out. The input-value bit is read-only and shows the pin level after a two-flop synchroniser.

A second register window holds the interrupt controls. Each pin has a polarity bit that chooses which single edge it catches, and a status bit that latches a caught edge. Software clears a status bit by writing 1 to it. The block has two outputs built from these: one combined interrupt line, formed from the pending bits that are enabled, and a wake request, formed from the pending bits that are marked for wake.

Software selects a window with `bus_win` and a 32-bit word with `bus_addr`, which is a word index. Read data is registered and appears one cycle after the address. To catch both edges on a pin, software flips that pin's polarity bit after each interrupt.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero and `pin_oe`, `pin_out`, `irq_out` and `wake_out` are all zero.
- R2: Pin control window (`bus_win`=0), by word index: 0/1 output enable, 4/5 input value, 6/7 output value. The odd index is the high bank (pins 32..63). Read data appears on `bus_rdata` one clock after the address is presented.
- R3: `pin_oe` follows the output-enable register and `pin_out` follows the output-value register, bit for bit per pin.
- R4: `pin_in` passes through two synchronising flops. A matching transition applied before clock edge k sets the status bit at edge k+2. The synchronised level is readable at the input-value word.
- R5: A polarity bit of 0 catches only rising edges and a polarity bit of 1 catches only falling edges. The opposite transition leaves the status bit unchanged.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an edge and a clear hit the same bit on the same edge, the bit stays set.
- R7: `irq_out` is registered and goes high one cycle after any status bit is set together with its enable bit. Status bits latch even while their enable bit is 0.
- R8: `wake_out` is registered and goes high one cycle after any status bit is set together with its wake bit.
- R9: Register bits at positions NPINS and above read as zero and ignore writes. Writes to the input-value words have no effect.
- R10: Interrupt window (`bus_win`=1), by word index: 0/1 enable, 2/3 polarity, 4/5 status, 6/7 wake. The odd index is the high bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_win | input | 1 | Window select: 0 pin control, 1 interrupt |
| bus_addr | input | 3 | Word index within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output levels to the pads |
| pin_oe | output | NPINS | Output-enable per pin |
| irq_out | output | 1 | Combined enabled-pending interrupt |
| wake_out | output | 1 | Wake request |

## Verification
A status bit stuck at 1 holds `irq_out` high once its pin is enabled, and software cannot clear it by writing 1. A status bit that never sets keeps the line low. Both faults show up within four cycles of the edge or the write. A polarity bit wired to the wrong sense makes the block catch the opposite transition, so the status word shows it one read later. Bits that should not exist show up as nonzero readback from the high bank on the next read.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANK_W = 32;
  localparam int TOT_W  = 2 * BANK_W;

  // word indices, bit 0 selects the high bank
  localparam logic [1:0] GW_OE  = 2'd0;
  localparam logic [1:0] GW_IN  = 2'd2;
  localparam logic [1:0] GW_OUT = 2'd3;
  localparam logic [1:0] IW_EN  = 2'd0;
  localparam logic [1:0] IW_POL = 2'd1;
  localparam logic [1:0] IW_ST  = 2'd2;
  localparam logic [1:0] IW_WK  = 2'd3;

  function automatic logic [TOT_W-1:0] impl_mask(input int n);
    logic [TOT_W-1:0] m;
    m = '0;
    for (int i = 0; i < TOT_W; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [TOT_W-1:0] bank_write(input logic [TOT_W-1:0] cur,
                                                  input logic hi,
                                                  input logic [BANK_W-1:0] d);
    return hi ? {d, cur[BANK_W-1:0]} : {cur[TOT_W-1:BANK_W], d};
  endfunction

  function automatic logic [BANK_W-1:0] bank_pick(input logic [TOT_W-1:0] v,
                                                  input logic hi);
    return hi ? v[TOT_W-1:BANK_W] : v[BANK_W-1:0];
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int NBITS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] raw,
  input  logic [NBITS-1:0] pol,
  output logic [NBITS-1:0] level,
  output logic [NBITS-1:0] hit
);
  for (genvar i = 0; i < NBITS; i++) begin : g_pin
    logic s1, s2, prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= 1'b0;
        s2   <= 1'b0;
        prev <= 1'b0;
      end else begin
        s1   <= raw[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign level[i] = s2;
    // polarity 0: low-to-high, polarity 1: high-to-low
    assign hit[i] = pol[i] ? (prev & ~s2) : (s2 & ~prev);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq import gpio_edge_pkg::*; #(
  parameter int NPINS = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        word,
  input  logic [BANK_W-1:0] wdata,
  input  logic [TOT_W-1:0]  hit,
  output logic [TOT_W-1:0]  en_q,
  output logic [TOT_W-1:0]  pol_q,
  output logic [TOT_W-1:0]  st_q,
  output logic [TOT_W-1:0]  wk_q,
  output logic              irq_q,
  output logic              wake_q
);
  localparam logic [TOT_W-1:0] IMPL = impl_mask(NPINS);

  logic [TOT_W-1:0] clr_vec;
  logic             hi;

  assign hi      = word[0];
  assign clr_vec = (we && word[2:1] == IW_ST) ? bank_write('0, hi, wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pol_q  <= '0;
      st_q   <= '0;
      wk_q   <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (we) begin
        case (word[2:1])
          IW_EN:   en_q  <= bank_write(en_q,  hi, wdata) & IMPL;
          IW_POL:  pol_q <= bank_write(pol_q, hi, wdata) & IMPL;
          IW_WK:   wk_q  <= bank_write(wk_q,  hi, wdata) & IMPL;
          default: ;
        endcase
      end
      // a new edge wins over a clear in the same cycle
      st_q   <= ((st_q & ~clr_vec) | hit) & IMPL;
      irq_q  <= |(st_q & en_q);
      wake_q <= |(st_q & wk_q);
    end
  end

  assert_edge_latched_R4: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((st_q & $past(hit & IMPL)) == $past(hit & IMPL)));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    ((~st_q & $past(st_q) & ~$past(clr_vec)) == '0));

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(en_q) == '0) |-> !irq_q);

  assert_wake_needs_bit_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(wk_q) == '0) |-> !wake_q);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank import gpio_edge_pkg::*; #(
  parameter int NPINS = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_win,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out,
  output logic              wake_out
);
  localparam logic [TOT_W-1:0] IMPL = impl_mask(NPINS);

  logic [TOT_W-1:0]  oe_q, ov_q, pin_w, level_w, hit_w;
  logic [TOT_W-1:0]  en_w, pol_w, st_w, wk_w;
  logic [BANK_W-1:0] rd_n, rd_q;
  logic              hi, gpio_we, irq_we;

  assign hi      = bus_addr[0];
  assign gpio_we = bus_we & ~bus_win;
  assign irq_we  = bus_we &  bus_win;

  always_comb begin
    pin_w = '0;
    pin_w[NPINS-1:0] = pin_in;
  end

  gpio_edge_sync #(.NBITS(TOT_W)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   (pin_w),
    .pol   (pol_w),
    .level (level_w),
    .hit   (hit_w)
  );

  gpio_edge_irq #(.NPINS(NPINS)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .we     (irq_we),
    .word   (bus_addr),
    .wdata  (bus_wdata),
    .hit    (hit_w),
    .en_q   (en_w),
    .pol_q  (pol_w),
    .st_q   (st_w),
    .wk_q   (wk_w),
    .irq_q  (irq_out),
    .wake_q (wake_out)
  );

  // pin control registers; input-value words are read-only
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= '0;
      ov_q <= '0;
    end else if (gpio_we) begin
      case (bus_addr[2:1])
        GW_OE:   oe_q <= bank_write(oe_q, hi, bus_wdata) & IMPL;
        GW_OUT:  ov_q <= bank_write(ov_q, hi, bus_wdata) & IMPL;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    if (!bus_win) begin
      case (bus_addr[2:1])
        GW_OE:   rd_n = bank_pick(oe_q, hi);
        GW_IN:   rd_n = bank_pick(level_w & IMPL, hi);
        GW_OUT:  rd_n = bank_pick(ov_q, hi);
        default: rd_n = '0;
      endcase
    end else begin
      case (bus_addr[2:1])
        IW_EN:   rd_n = bank_pick(en_w, hi);
        IW_POL:  rd_n = bank_pick(pol_w, hi);
        IW_ST:   rd_n = bank_pick(st_w, hi);
        default: rd_n = bank_pick(wk_w, hi);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign bus_rdata = rd_q;
  assign pin_oe    = oe_q[NPINS-1:0];
  assign pin_out   = ov_q[NPINS-1:0];

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (((oe_q | ov_q | en_w | pol_w | st_w | wk_w) & ~IMPL) == '0));
endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  localparam int CLK_P = 10;
  localparam int NP    = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_win = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_out, wake_out;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_edge_bank #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_win(bus_win), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_out(irq_out), .wake_out(wake_out)
  );

  // {window, word, write data, expected readback}
  localparam logic [67:0] VEC [9] = '{
    {1'b0, 3'd0, 32'hA5A5A5A5, 32'hA5A5A5A5},  // R2 oe low
    {1'b0, 3'd1, 32'hFFFFFFFF, 32'h0000000F},  // R9 oe high, 4 pins
    {1'b0, 3'd6, 32'h12345678, 32'h12345678},  // R2 out low
    {1'b0, 3'd7, 32'hFFFFFFF5, 32'h00000005},  // R9 out high
    {1'b0, 3'd4, 32'hFFFFFFFF, 32'h00000000},  // R9 input read-only
    {1'b1, 3'd0, 32'h0000F00F, 32'h0000F00F},  // R10 enable low
    {1'b1, 3'd3, 32'hFFFFFFFF, 32'h0000000F},  // R10 polarity high
    {1'b1, 3'd4, 32'hFFFFFFFF, 32'h00000000},  // R6 status W1C on zero
    {1'b1, 3'd7, 32'h00000003, 32'h00000003}   // R10 wake high
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_win = w; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic w, input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_win = w; bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(1'b0, 3'd0, d);
    chk("R1 oe after reset", d, 0);
    chk("R1 outputs after reset", {pin_oe, pin_out, irq_out, wake_out}, 0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][67], VEC[i][66:64], VEC[i][63:32]);
      rd(VEC[i][67], VEC[i][66:64], d);
      chk($sformatf("R2/R9/R10 vector %0d", i), d, VEC[i][31:0]);
    end
    // R3 pad outputs follow registers
    chk("R3 pin_oe", pin_oe, {4'hF, 32'hA5A5A5A5});
    chk("R3 pin_out", pin_out, {4'h5, 32'h12345678});

    // prepare interrupt window
    wr(1'b1, 3'd0, 0);
    wr(1'b1, 3'd2, 0);
    wr(1'b1, 3'd3, 32'h2);
    wr(1'b1, 3'd7, 0);

    // R4/R7 rising edge on pin 3 latches while disabled
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    rd(1'b1, 3'd4, d);
    chk("R4 status bit3 set by rise", d, 32'h8);
    chk("R7 irq low while disabled", irq_out, 0);
    wr(1'b1, 3'd0, 32'h8);
    @(negedge clk);
    chk("R7 irq after unmask", irq_out, 1);

    // R5 falling edge ignored with polarity 0
    wr(1'b1, 3'd4, 32'h8);
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    rd(1'b1, 3'd4, d);
    chk("R5 fall ignored pol0", d, 0);
    chk("R7 irq low after clear", irq_out, 0);

    // R5 pin 33 with polarity 1
    @(negedge clk); pin_in[33] = 1'b1;
    settle();
    rd(1'b1, 3'd5, d);
    chk("R5 rise ignored pol1", d, 0);
    @(negedge clk); pin_in[33] = 1'b0;
    settle();
    rd(1'b1, 3'd5, d);
    chk("R5 fall caught pol1", d, 32'h2);
    chk("R8 wake low without wake bit", wake_out, 0);
    wr(1'b1, 3'd7, 32'h2);
    @(negedge clk);
    chk("R8 wake raised", wake_out, 1);

    // R4 synchronised level readable
    @(negedge clk); pin_in[5] = 1'b1;
    settle();
    rd(1'b0, 3'd4, d);
    chk("R4 input value", d, 32'h20);

    // R6 edge and clear in the same cycle
    @(negedge clk); pin_in[3] = 1'b1;
    settle();
    @(negedge clk); pin_in[3] = 1'b0;
    settle();
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_win = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h8; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(1'b1, 3'd4, d);
    chk("R6 edge beats clear", d & 32'h8, 32'h8);
    wr(1'b1, 3'd4, 32'h0);
    rd(1'b1, 3'd4, d);
    chk("R6 write zero keeps", d & 32'h8, 32'h8);
    wr(1'b1, 3'd4, 32'h8);
    rd(1'b1, 3'd4, d);
    chk("R6 write one clears", d & 32'h8, 0);

    // R1 reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(1'b1, 3'd5, d);
    chk("R1 status after reset", d, 0);
    chk("R1 outputs after reset", {pin_oe, pin_out, irq_out, wake_out}, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule